// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Controller

This block looks after one isochronous OUT endpoint in a USB device controller. Firmware arms it with a byte budget, a packet count and a frame-parity selector. From then on it accepts data packets only in frames whose number has the selected parity. It counts down packets and bytes as each packet finishes draining from the receive FIFO, and it keeps the data PID of the last packet it accepted.

A transfer ends in one of two ways. The packet count can reach zero, or a short packet can arrive. In that case the block raises a transfer-complete pulse. If instead the end-of-periodic-frame strobe comes first, in the frame the endpoint was armed for, the block raises an incomplete-frame pulse. In both cases it disarms itself (endpoint disabled, NAK set) and gives a one-cycle verdict. The verdict says whether the last data PID agrees with the number of packets received, and it carries the packet count and the remaining byte budget.

The packet interface is abstract. Serial decoding, FIFO storage and DMA sit outside the block.

Top module: `iso_out_ep_rx`

## Requirements
- R1: A packet is accepted only when the armed parity selector (0 = even, 1 = odd) equals bit 0 of `frame_num`. Packets in frames of the other parity change no counter and no output.
- R2: A `cfg_wr` arms the endpoint only when `cfg_ep_en`=1, `cfg_clr_nak`=1 and `cfg_pkt_cnt`≠0 are all true in the same cycle. Any other write has no effect.
- R3: Each accepted packet updates `rx_pid_code` one cycle later (0 = DATA0, 1 = DATA1, 2 = DATA2). No other event changes it. Its reset value is 0.
- R4: The PID codes are DATA0 = 4'b0011, DATA1 = 4'b1011 and DATA2 = 4'b0111. A packet with any other PID is dropped and changes no counter and no output.
- R5: Each accepted packet lowers the remaining packet count by 1 and the remaining byte budget by its byte count. The byte budget saturates at 0.
- R6: `xfer_cmpl` pulses when an accepted packet brings the packet count to 0, or when it carries fewer than `MAX_PKT` bytes.
- R7: `res_pkts` equals the armed packet count minus the remaining packet count. `res_good` is 1 only for last PID DATA0 with 1 packet, DATA1 with 2 packets, or DATA2 with 3 packets.
- R8: `eopf_stb` raises `iso_incomplete` when it arrives while the endpoint is armed, the transfer is unfinished, and the current frame parity matches the selector. `xfer_cmpl` and `iso_incomplete` never pulse together.
- R9: `eopf_stb` in a frame of the non-selected parity has no effect.
- R10: After completion or an incomplete event, `ep_armed` drops to 0 (disabled with NAK set). It stays 0 until a valid re-arm, and packets arriving meanwhile are ignored.
- R11: `res_valid` and the event pulse are high for exactly the one cycle after the clock edge that takes the final packet or the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_ep_en | input | 1 | Endpoint enable bit of the write |
| cfg_clr_nak | input | 1 | Clear-NAK bit of the write |
| cfg_odd_frame | input | 1 | Frame parity selector, 1 = odd |
| cfg_xfer_size | input | SIZE_W | Byte budget to load |
| cfg_pkt_cnt | input | PKT_W | Packet count to load |
| frame_num | input | FRAME_W | Current frame number |
| eopf_stb | input | 1 | End-of-periodic-frame strobe |
| pkt_done | input | 1 | Packet and its status fully drained from the FIFO |
| pkt_pid | input | 4 | Data PID of that packet |
| pkt_bytes | input | BYTE_W | Byte count of that packet |
| ep_armed | output | 1 | Endpoint enabled with NAK cleared |
| rx_pid_code | output | 2 | Last accepted data PID code |
| xfer_cmpl | output | 1 | Transfer-complete pulse |
| iso_incomplete | output | 1 | Incomplete-frame pulse |
| res_valid | output | 1 | Verdict valid pulse |
| res_good | output | 1 | Payload PID and count agree |
| res_pkts | output | PKT_W | Packets received in this transfer |
| res_size_left | output | SIZE_W | Remaining byte budget |

## Verification
The bench targets packets in the wrong-parity frame and packets with a bogus PID, since a design that failed to gate them would lower the counters and finish early. It covers a short packet ending a multi-packet transfer and an oversized packet against a small budget. A design that got these wrong would miss the completion or wrap the byte budget to a large value. It checks an end-of-frame strobe in both the matching and the non-matching frame, because an incorrect design would abort transfers armed for the next frame. It also checks that PID and count pairings such as DATA0 after two packets come back as bad, where a design that looked at the PID alone would report them as good.

// File: rtl/iso_rx_pkg.sv
// Package: shared PID codes and the payload verdict rule.
// Assumes 4-bit PID fields as seen after decoding.
package iso_rx_pkg;

    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;
    localparam logic [3:0] PID_DATA2 = 4'b0111;

    typedef enum logic [1:0] {
        RXPID_D0   = 2'd0,
        RXPID_D1   = 2'd1,
        RXPID_D2   = 2'd2,
        RXPID_NONE = 2'd3
    } rxpid_e;

    // Map a raw PID to its short code; NONE for anything not a data PID.
    function automatic rxpid_e pid_classify(input logic [3:0] pid);
        case (pid)
            PID_DATA0: return RXPID_D0;
            PID_DATA1: return RXPID_D1;
            PID_DATA2: return RXPID_D2;
            default:   return RXPID_NONE;
        endcase
    endfunction

    // Payload is good only when the last PID matches the packet count.
    function automatic logic payload_ok(input rxpid_e code, input int unsigned npkt);
        return (code == RXPID_D0 && npkt == 1) ||
               (code == RXPID_D1 && npkt == 2) ||
               (code == RXPID_D2 && npkt == 3);
    endfunction

endpackage

// File: rtl/iso_rx_gate.sv
// Module: acceptance gate for drained packets.
// Decides whether a packet counts: endpoint armed, frame parity matches
// the selector, and the PID is a data PID. Purely combinational.
module iso_rx_gate
    import iso_rx_pkg::*;
(
    input  logic       armed,
    input  logic       odd_sel,
    input  logic       frame_lsb,
    input  logic       pkt_done,
    input  logic [3:0] pkt_pid,
    output logic       accept,
    output rxpid_e     pid_code
);

    // Classify the PID and qualify the strobe.
    always_comb begin
        pid_code = pid_classify(pkt_pid);
        accept   = pkt_done && armed && (frame_lsb == odd_sel) &&
                   (pid_code != RXPID_NONE);
    end

endmodule

// File: rtl/iso_rx_xfer.sv
// Module: transfer state of the endpoint.
// Holds the armed flag, parity selector, armed and remaining packet counts,
// remaining byte budget and last PID. Flags the end-of-transfer events.
// Assumes an arming write in the same cycle as a packet takes priority.
module iso_rx_xfer
    import iso_rx_pkg::*;
#(
    parameter int SIZE_W  = 11,
    parameter int PKT_W   = 2,
    parameter int MAX_PKT = 64,
    parameter int BYTE_W  = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_ep_en,
    input  logic              cfg_clr_nak,
    input  logic              cfg_odd_frame,
    input  logic [SIZE_W-1:0] cfg_xfer_size,
    input  logic [PKT_W-1:0]  cfg_pkt_cnt,
    input  logic              accept,
    input  rxpid_e            pid_code,
    input  logic [BYTE_W-1:0] pkt_bytes,
    input  logic              eopf_stb,
    input  logic              frame_lsb,
    output logic              armed,
    output logic              odd_sel,
    output rxpid_e            rx_pid,
    output logic              done_evt,
    output logic              incomp_evt,
    output logic [PKT_W-1:0]  evt_pkts,
    output logic [SIZE_W-1:0] evt_size,
    output rxpid_e            evt_pid
);

    logic [PKT_W-1:0]  init_cnt;
    logic [PKT_W-1:0]  pkt_left;
    logic [SIZE_W-1:0] size_left;
    logic              arm_req;
    logic              take;
    logic [PKT_W-1:0]  left_dec;
    logic [SIZE_W-1:0] size_dec;
    logic [SIZE_W-1:0] bytes_ext;
    logic              short_pkt;

    // Next-count arithmetic and end-of-transfer detection.
    always_comb begin
        arm_req    = cfg_wr && cfg_ep_en && cfg_clr_nak && (cfg_pkt_cnt != '0);
        take       = accept && !arm_req;
        bytes_ext  = SIZE_W'(pkt_bytes);
        left_dec   = pkt_left - PKT_W'(1);
        size_dec   = (bytes_ext > size_left) ? '0 : (size_left - bytes_ext);
        short_pkt  = pkt_bytes < BYTE_W'(MAX_PKT);
        done_evt   = take && ((left_dec == '0) || short_pkt);
        incomp_evt = armed && !arm_req && eopf_stb && (frame_lsb == odd_sel) && !done_evt;
        evt_pkts   = init_cnt - (take ? left_dec : pkt_left);
        evt_size   = take ? size_dec : size_left;
        evt_pid    = take ? pid_code : rx_pid;
    end

    // State registers: arm load, per-packet countdown, self-disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            odd_sel   <= 1'b0;
            init_cnt  <= '0;
            pkt_left  <= '0;
            size_left <= '0;
            rx_pid    <= RXPID_D0;
        end else if (arm_req) begin
            armed     <= 1'b1;
            odd_sel   <= cfg_odd_frame;
            init_cnt  <= cfg_pkt_cnt;
            pkt_left  <= cfg_pkt_cnt;
            size_left <= cfg_xfer_size;
        end else begin
            if (take) begin
                rx_pid    <= pid_code;
                pkt_left  <= left_dec;
                size_left <= size_dec;
            end
            if (done_evt || incomp_evt) begin
                armed <= 1'b0;
            end
        end
    end

    // R1: the gate only passes packets of the selected frame parity
    assert_parity_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (frame_lsb == odd_sel));

    // R5: each accepted packet takes exactly one off the packet count
    assert_pkt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (pkt_left == $past(pkt_left) - PKT_W'(1)));

    // R10: the endpoint disarms after either terminating event
    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt || incomp_evt) |=> !armed);

    // R2: a valid arming write leaves the endpoint armed
    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> armed);

endmodule

// File: rtl/iso_rx_verdict.sv
// Module: result register stage.
// Registers the event pulses and the verdict so that all outputs change on
// the clock edge after the event. Holds result fields between events.
module iso_rx_verdict
    import iso_rx_pkg::*;
#(
    parameter int SIZE_W = 11,
    parameter int PKT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              incomp_evt,
    input  logic [PKT_W-1:0]  evt_pkts,
    input  logic [SIZE_W-1:0] evt_size,
    input  rxpid_e            evt_pid,
    output logic              xfer_cmpl,
    output logic              iso_incomplete,
    output logic              res_valid,
    output logic              res_good,
    output logic [PKT_W-1:0]  res_pkts,
    output logic [SIZE_W-1:0] res_size_left
);

    // Pulse outputs and latch verdict fields on any terminating event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_cmpl      <= 1'b0;
            iso_incomplete <= 1'b0;
            res_valid      <= 1'b0;
            res_good       <= 1'b0;
            res_pkts       <= '0;
            res_size_left  <= '0;
        end else begin
            xfer_cmpl      <= done_evt;
            iso_incomplete <= incomp_evt;
            res_valid      <= done_evt || incomp_evt;
            if (done_evt || incomp_evt) begin
                res_good      <= payload_ok(evt_pid, int'(evt_pkts));
                res_pkts      <= evt_pkts;
                res_size_left <= evt_size;
            end else begin
                res_good      <= 1'b0;
            end
        end
    end

    // R8: the two terminating events are exclusive
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_cmpl && iso_incomplete));

    // R7: a good verdict implies a packet count of 1 to 3
    assert_good_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_good |-> (res_valid && res_pkts != '0));

    // R11: the verdict strobe only accompanies an event pulse
    assert_valid_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (xfer_cmpl || iso_incomplete));

    // R11: completion is a single-cycle pulse
    assert_cmpl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmpl |=> !xfer_cmpl);

endmodule

// File: rtl/iso_out_ep_rx.sv
// Module: isochronous OUT endpoint receive controller (top).
// Connects the acceptance gate, the transfer state and the result stage.
// Assumes pkt_done marks a packet whose data and status have left the FIFO,
// and that frame_num is stable for the whole frame.
module iso_out_ep_rx
    import iso_rx_pkg::*;
#(
    parameter int SIZE_W  = 11,
    parameter int PKT_W   = 2,
    parameter int FRAME_W = 11,
    parameter int MAX_PKT = 64,
    parameter int BYTE_W  = $clog2(MAX_PKT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_ep_en,
    input  logic               cfg_clr_nak,
    input  logic               cfg_odd_frame,
    input  logic [SIZE_W-1:0]  cfg_xfer_size,
    input  logic [PKT_W-1:0]   cfg_pkt_cnt,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               eopf_stb,
    input  logic               pkt_done,
    input  logic [3:0]         pkt_pid,
    input  logic [BYTE_W-1:0]  pkt_bytes,
    output logic               ep_armed,
    output logic [1:0]         rx_pid_code,
    output logic               xfer_cmpl,
    output logic               iso_incomplete,
    output logic               res_valid,
    output logic               res_good,
    output logic [PKT_W-1:0]   res_pkts,
    output logic [SIZE_W-1:0]  res_size_left
);

    logic              armed;
    logic              odd_sel;
    logic              accept;
    rxpid_e            pid_code;
    rxpid_e            rx_pid;
    logic              done_evt;
    logic              incomp_evt;
    logic [PKT_W-1:0]  evt_pkts;
    logic [SIZE_W-1:0] evt_size;
    rxpid_e            evt_pid;

    iso_rx_gate u_gate (
        .armed     (armed),
        .odd_sel   (odd_sel),
        .frame_lsb (frame_num[0]),
        .pkt_done  (pkt_done),
        .pkt_pid   (pkt_pid),
        .accept    (accept),
        .pid_code  (pid_code)
    );

    iso_rx_xfer #(
        .SIZE_W  (SIZE_W),
        .PKT_W   (PKT_W),
        .MAX_PKT (MAX_PKT),
        .BYTE_W  (BYTE_W)
    ) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_ep_en     (cfg_ep_en),
        .cfg_clr_nak   (cfg_clr_nak),
        .cfg_odd_frame (cfg_odd_frame),
        .cfg_xfer_size (cfg_xfer_size),
        .cfg_pkt_cnt   (cfg_pkt_cnt),
        .accept        (accept),
        .pid_code      (pid_code),
        .pkt_bytes     (pkt_bytes),
        .eopf_stb      (eopf_stb),
        .frame_lsb     (frame_num[0]),
        .armed         (armed),
        .odd_sel       (odd_sel),
        .rx_pid        (rx_pid),
        .done_evt      (done_evt),
        .incomp_evt    (incomp_evt),
        .evt_pkts      (evt_pkts),
        .evt_size      (evt_size),
        .evt_pid       (evt_pid)
    );

    iso_rx_verdict #(
        .SIZE_W (SIZE_W),
        .PKT_W  (PKT_W)
    ) u_verdict (
        .clk            (clk),
        .rst_n          (rst_n),
        .done_evt       (done_evt),
        .incomp_evt     (incomp_evt),
        .evt_pkts       (evt_pkts),
        .evt_size       (evt_size),
        .evt_pid        (evt_pid),
        .xfer_cmpl      (xfer_cmpl),
        .iso_incomplete (iso_incomplete),
        .res_valid      (res_valid),
        .res_good       (res_good),
        .res_pkts       (res_pkts),
        .res_size_left  (res_size_left)
    );

    // Expose endpoint state.
    always_comb begin
        ep_armed    = armed;
        rx_pid_code = rx_pid;
    end

endmodule

// File: tb/iso_out_ep_rx_tb_top.sv
// Bench: directed corner cases followed by seeded random operations,
// checked against a reference model written from the requirements.
module iso_out_ep_rx_tb_top;

    localparam int SIZE_W  = 11;
    localparam int PKT_W   = 2;
    localparam int FRAME_W = 11;
    localparam int MAX_PKT = 64;
    localparam int BYTE_W  = $clog2(MAX_PKT + 1);
    localparam logic [3:0] D0 = 4'b0011;
    localparam logic [3:0] D1 = 4'b1011;
    localparam logic [3:0] D2 = 4'b0111;
    localparam logic [3:0] BOGUS = 4'b1001;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic               cfg_ep_en = 1'b0;
    logic               cfg_clr_nak = 1'b0;
    logic               cfg_odd_frame = 1'b0;
    logic [SIZE_W-1:0]  cfg_xfer_size = '0;
    logic [PKT_W-1:0]   cfg_pkt_cnt = '0;
    logic [FRAME_W-1:0] frame_num = '0;
    logic               eopf_stb = 1'b0;
    logic               pkt_done = 1'b0;
    logic [3:0]         pkt_pid = 4'h0;
    logic [BYTE_W-1:0]  pkt_bytes = '0;
    logic               ep_armed;
    logic [1:0]         rx_pid_code;
    logic               xfer_cmpl;
    logic               iso_incomplete;
    logic               res_valid;
    logic               res_good;
    logic [PKT_W-1:0]   res_pkts;
    logic [SIZE_W-1:0]  res_size_left;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_armed = 1'b0;
    bit m_odd = 1'b0;
    int m_init = 0;
    int m_left = 0;
    int m_size = 0;
    int m_pid = 0;

    always #10 clk = ~clk;

    iso_out_ep_rx #(
        .SIZE_W (SIZE_W), .PKT_W (PKT_W), .FRAME_W (FRAME_W), .MAX_PKT (MAX_PKT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_ep_en (cfg_ep_en),
        .cfg_clr_nak (cfg_clr_nak), .cfg_odd_frame (cfg_odd_frame),
        .cfg_xfer_size (cfg_xfer_size), .cfg_pkt_cnt (cfg_pkt_cnt),
        .frame_num (frame_num), .eopf_stb (eopf_stb), .pkt_done (pkt_done),
        .pkt_pid (pkt_pid), .pkt_bytes (pkt_bytes), .ep_armed (ep_armed),
        .rx_pid_code (rx_pid_code), .xfer_cmpl (xfer_cmpl),
        .iso_incomplete (iso_incomplete), .res_valid (res_valid),
        .res_good (res_good), .res_pkts (res_pkts), .res_size_left (res_size_left)
    );

    function automatic int pid_code_of(input logic [3:0] p);
        if (p == D0) return 0;
        if (p == D1) return 1;
        if (p == D2) return 2;
        return 3;
    endfunction

    function automatic int good_of(input int code, input int n);
        return ((code == 0 && n == 1) || (code == 1 && n == 2) || (code == 2 && n == 3)) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int ec, input int ei, input int eg, input int ep, input int es);
        chk("R6", "xfer_cmpl", int'(xfer_cmpl), ec);
        chk("R8", "iso_incomplete", int'(iso_incomplete), ei);
        chk("R11", "res_valid", int'(res_valid), (ec | ei));
        if ((ec | ei) != 0) begin
            chk("R7", "res_good", int'(res_good), eg);
            chk("R7", "res_pkts", int'(res_pkts), ep);
            chk("R5", "res_size_left", int'(res_size_left), es);
        end
        chk("R10", "ep_armed", int'(ep_armed), int'(m_armed));
        chk("R3", "rx_pid_code", int'(rx_pid_code), m_pid);
    endtask

    // R2: arming write, modelled only when all three conditions hold
    task automatic do_arm(input bit en, input bit cn, input bit odd, input int size, input int cnt);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ep_en = en; cfg_clr_nak = cn; cfg_odd_frame = odd;
        cfg_xfer_size = SIZE_W'(size); cfg_pkt_cnt = PKT_W'(cnt);
        if (en && cn && cnt != 0) begin
            m_armed = 1'b1; m_odd = odd; m_init = cnt; m_left = cnt; m_size = size;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        check_all(0, 0, 0, 0, 0);
    endtask

    task automatic do_pkt(input logic [3:0] pid, input int bytes);
        int ec, eg, ep, es, code;
        ec = 0; eg = 0; ep = 0; es = 0;
        code = pid_code_of(pid);
        @(negedge clk);
        pkt_done = 1'b1; pkt_pid = pid; pkt_bytes = BYTE_W'(bytes);
        if (m_armed && (m_odd == frame_num[0]) && code != 3) begin
            m_pid = code;
            m_left = m_left - 1;
            m_size = (bytes > m_size) ? 0 : m_size - bytes;
            if (m_left == 0 || bytes < MAX_PKT) begin
                ec = 1; ep = m_init - m_left; es = m_size;
                eg = good_of(m_pid, ep);
                m_armed = 1'b0;
            end
        end
        @(negedge clk);
        pkt_done = 1'b0;
        check_all(ec, 0, eg, ep, es);
    endtask

    task automatic do_eopf();
        int ei, eg, ep, es;
        ei = 0; eg = 0; ep = 0; es = 0;
        @(negedge clk);
        eopf_stb = 1'b1;
        if (m_armed && (m_odd == frame_num[0])) begin
            ei = 1; ep = m_init - m_left; es = m_size;
            eg = good_of(m_pid, ep);
            m_armed = 1'b0;
        end
        @(negedge clk);
        eopf_stb = 1'b0;
        check_all(0, ei, eg, ep, es);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(0, 0, 0, 0, 0);                 // reset state, R3 pid 0

        // R2: incomplete arming writes have no effect
        do_arm(1, 0, 0, 100, 1);
        do_arm(0, 1, 0, 100, 1);
        do_arm(1, 1, 0, 100, 0);

        // basic single packet, even frame
        frame_num = 11'd4;
        do_arm(1, 1, 0, 200, 1);
        do_pkt(D0, 40);                          // R6 short, R7 good, R5 size 160

        // R1: wrong parity ignored; R9: eopf in other frame ignored
        do_arm(1, 1, 1, 300, 2);
        frame_num = 11'd6;
        do_pkt(D1, 64);
        do_eopf();
        frame_num = 11'd7;
        do_pkt(D1, 64);
        do_pkt(D0, 64);                          // R7 DATA0 after 2 packets: bad

        // three packets ending DATA2
        frame_num = 11'd8;
        do_arm(1, 1, 0, 500, 3);
        do_pkt(D0, 64);
        do_pkt(D1, 64);
        do_pkt(D2, 64);

        // R4: bogus PID dropped
        do_arm(1, 1, 0, 100, 1);
        do_pkt(BOGUS, 10);
        do_pkt(D0, 64);

        // R6: short packet ends a 3-packet transfer
        do_arm(1, 1, 0, 400, 3);
        do_pkt(D1, 64);
        do_pkt(D1, 20);

        // R5: byte budget saturates
        do_arm(1, 1, 0, 50, 2);
        do_pkt(D0, 64);
        do_pkt(D1, 64);

        // R8: incomplete on matching frame end
        frame_num = 11'd10;
        do_arm(1, 1, 0, 300, 2);
        do_pkt(D0, 64);
        do_eopf();

        // R10: packets while disarmed are ignored
        do_pkt(D2, 5);

        // random operations
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 8);
            if (op == 0) begin
                do_arm(($urandom % 5) != 0, ($urandom % 5) != 0, $urandom % 2,
                       int'($urandom % 300), int'($urandom % 4));
            end else if (op == 1) begin
                @(negedge clk);
                frame_num = FRAME_W'($urandom);
            end else if (op == 2) begin
                do_eopf();
            end else begin
                int sel, by;
                logic [3:0] p;
                sel = int'($urandom % 4);
                p = (sel == 0) ? D0 : (sel == 1) ? D1 : (sel == 2) ? D2 : BOGUS;
                by = (($urandom % 10) < 7) ? MAX_PKT : int'($urandom % (MAX_PKT + 1));
                do_pkt(p, by);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule